// File: doc/BRIEF.md
# Locked Banked Test-Register Front End

This block sits on the slave side of a 32-entry, 16-bit management register space. Behind three of those addresses it hides a second register space: four banks of 32 words each. One address is a control word, one returns indirectly read data, and one stages indirectly written data. The hidden space stays sealed until the control word receives a fixed toggle pattern. Once it is open, software reaches any banked word through that trio. Every other management address is a plain read/write register.

A second port lets the surrounding logic read and write the banked words directly. It models the hardware side that owns those registers. Banks 0, 1 and 3 hold storage. Bank 2 is empty. The management port has a single-cycle write strobe and a combinational read mux on the current address. The serial framing that would normally carry these accesses belongs to another block.

Top module: `mgmt_test_bank_regs`

## Requirements
- R1: After reset the banked space is locked and every management register, including the control word (address 20), indirect read data (address 21), write staging (address 23) and all banked words, reads 0.
- R2: The banked space opens on the clock edge of the fourth of four control writes carrying 0x0000, 0x0400, 0x0000, 0x0400 in that order. Writes to other addresses between them do not disturb the tracking.
- R3: A control write that does not match the expected next value of the pattern returns the tracker to idle. If that mismatching value is 0x0000, it counts as the first step of a new pattern.
- R4: Writing 0x0000 to the control word while open locks the banked space again.
- R5: The control word keeps bits 12:0 as written: bank select in 12:11, test-mode enable in 10, read address in 9:5, write address in 4:0. Bit 15 (read command) and bit 14 (write command) act only in the cycle of the write and always read back as 0.
- R6: While open, a control write with bits 15 and 10 set captures the banked word named by bits 12:11 and 9:5. That word appears at address 21 from the next cycle.
- R7: Address 23 holds the value written to it and reads it back. While open, a control write with bits 14 and 10 set copies that staged value into the banked word named by bits 12:11 and 4:0.
- R8: While locked, read and write commands leave the banked words unchanged, and address 21 reads 0.
- R9: A read or write command whose bit 10 is clear has no effect, even while open.
- R10: Bank 2 holds no storage. It reads 0 on both ports and ignores writes from both ports.
- R11: The core port writes the banked word selected by core_bank and core_addr on a core_we cycle. core_rdata shows that word combinationally.
- R12: When a management commit and a core write hit the same banked word in one cycle, the management value is kept. When they hit different words, both are stored.
- R13: Management addresses other than 20, 21 and 23 are plain read/write registers. Address 21 is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_addr | input | 5 | Management register address |
| mgmt_wdata | input | 16 | Management write data |
| mgmt_rdata | output | 16 | Management read data for mgmt_addr |
| core_we | input | 1 | Core-side banked write strobe |
| core_bank | input | 2 | Core-side bank select |
| core_addr | input | 5 | Core-side word address |
| core_wdata | input | 16 | Core-side write data |
| core_rdata | output | 16 | Core-side banked read data |

## Verification
A management commit through the control word and a core-side write can land on the banked storage in the same clock edge. The bench provokes this by raising core_we in the very cycle of a write command, once aimed at the same bank word and once at a neighbouring word. The result is judged on core_rdata afterwards: the shared word must hold the staged management value, and the two separate words must each hold their own value.

// File: rtl/mtb_pkg.sv
package mtb_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 5;
    localparam int BANK_W    = 2;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = 5'd20;
    localparam logic [ADDR_W-1:0] RDAT_ADDR = 5'd21;
    localparam logic [ADDR_W-1:0] WDAT_ADDR = 5'd23;

    localparam int RD_CMD_BIT = 15;
    localparam int WR_CMD_BIT = 14;
    localparam int BANK_LO    = 11;
    localparam int TEST_BIT   = 10;
    localparam int RADDR_LO   = 5;
    localparam int WADDR_LO   = 0;

    localparam logic [DATA_W-1:0] KEY_LOW   = 16'h0000;
    localparam logic [DATA_W-1:0] KEY_HIGH  = 16'h0400;
    localparam logic [DATA_W-1:0] CTRL_KEEP = 16'h1FFF;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_LOW1,
        SEQ_HIGH1,
        SEQ_LOW2,
        SEQ_OPEN
    } seq_e;
endpackage

// File: rtl/mtb_unlock.sv
module mtb_unlock
    import mtb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [DATA_W-1:0] ctl_wdata,
    output logic              open_o
);
    typedef struct packed {
        seq_e st;
    } trk_t;

    trk_t trk_d, trk_q;
    logic is_low, is_high;

    always_comb begin
        trk_d   = trk_q;
        is_low  = (ctl_wdata == KEY_LOW);
        is_high = (ctl_wdata == KEY_HIGH);
        if (ctl_we) begin
            case (trk_q.st)
                SEQ_IDLE:  trk_d.st = is_low  ? SEQ_LOW1 : SEQ_IDLE;
                SEQ_LOW1:  trk_d.st = is_high ? SEQ_HIGH1 : (is_low ? SEQ_LOW1 : SEQ_IDLE);
                SEQ_HIGH1: trk_d.st = is_low  ? SEQ_LOW2 : SEQ_IDLE;
                SEQ_LOW2:  trk_d.st = is_high ? SEQ_OPEN : (is_low ? SEQ_LOW1 : SEQ_IDLE);
                SEQ_OPEN:  trk_d.st = is_low  ? SEQ_LOW1 : SEQ_OPEN;
                default:   trk_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '{st: SEQ_IDLE};
        else        trk_q <= trk_d;
    end

    assign open_o = (trk_q.st == SEQ_OPEN);

    // R2
    unlock_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(ctl_we && ctl_wdata == KEY_HIGH));

    // R3
    seq_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && trk_q.st != SEQ_OPEN && ctl_wdata != KEY_LOW && ctl_wdata != KEY_HIGH)
        |=> (trk_q.st == SEQ_IDLE));

    // R4
    close_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && open_o && ctl_wdata == KEY_LOW) |=> !open_o);
endmodule

// File: rtl/mtb_bank_store.sv
module mtb_bank_store #(
    parameter int          BANK_W   = 2,
    parameter int          AW       = 5,
    parameter int          DW       = 16,
    parameter logic [3:0]  POP_MASK = 4'b1011
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_we,
    input  logic [BANK_W-1:0] m_wbank,
    input  logic [AW-1:0]     m_waddr,
    input  logic [DW-1:0]     m_wdata,
    input  logic [BANK_W-1:0] m_rbank,
    input  logic [AW-1:0]     m_raddr,
    output logic [DW-1:0]     m_rdata,
    input  logic              i_we,
    input  logic [BANK_W-1:0] i_bank,
    input  logic [AW-1:0]     i_addr,
    input  logic [DW-1:0]     i_wdata,
    output logic [DW-1:0]     i_rdata
);
    localparam int NBANK = 1 << BANK_W;
    localparam int DEPTH = 1 << AW;

    logic [NBANK-1:0][DW-1:0] rd_m, rd_i;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        if (POP_MASK[b]) begin : g_pop
            logic [DW-1:0] mem_d [DEPTH];
            logic [DW-1:0] mem_q [DEPTH];

            always_comb begin
                mem_d = mem_q;
                if (i_we && i_bank == BANK_W'(b)) mem_d[i_addr]  = i_wdata;
                if (m_we && m_wbank == BANK_W'(b)) mem_d[m_waddr] = m_wdata;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
                end else begin
                    mem_q <= mem_d;
                end
            end

            assign rd_m[b] = mem_q[m_raddr];
            assign rd_i[b] = mem_q[i_addr];

            // R12
            collide_mgmt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (m_we && i_we && m_wbank == BANK_W'(b) && i_bank == BANK_W'(b) && m_waddr == i_addr)
                |=> (mem_q[$past(m_waddr)] == $past(m_wdata)));
        end else begin : g_empty
            assign rd_m[b] = '0;
            assign rd_i[b] = '0;
        end
    end

    assign m_rdata = rd_m[m_rbank];
    assign i_rdata = rd_i[i_bank];

    // R10
    empty_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !POP_MASK[i_bank] |-> (i_rdata == '0));
endmodule

// File: rtl/mgmt_test_bank_regs.sv
module mgmt_test_bank_regs
    import mtb_pkg::*;
#(
    parameter logic [3:0] POP_MASK = 4'b1011
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_we,
    input  logic [4:0]  mgmt_addr,
    input  logic [15:0] mgmt_wdata,
    output logic [15:0] mgmt_rdata,
    input  logic        core_we,
    input  logic [1:0]  core_bank,
    input  logic [4:0]  core_addr,
    input  logic [15:0] core_wdata,
    output logic [15:0] core_rdata
);
    localparam int NREG = 1 << ADDR_W;

    typedef struct packed {
        logic [DATA_W-1:0]            ctrl;
        logic [DATA_W-1:0]            rd_latch;
        logic [DATA_W-1:0]            wr_stage;
        logic [NREG-1:0][DATA_W-1:0]  plain;
    } regs_t;

    regs_t r_d, r_q;

    logic              open_q;
    logic              ctl_we, cmd_ok, do_rd, do_wr;
    logic [BANK_W-1:0] sel_bank;
    logic [ADDR_W-1:0] sel_raddr, sel_waddr;
    logic [DATA_W-1:0] str_rdata;

    assign ctl_we    = mgmt_we && (mgmt_addr == CTRL_ADDR);
    assign cmd_ok    = ctl_we && open_q && mgmt_wdata[TEST_BIT];
    assign do_rd     = cmd_ok && mgmt_wdata[RD_CMD_BIT];
    assign do_wr     = cmd_ok && mgmt_wdata[WR_CMD_BIT];
    assign sel_bank  = mgmt_wdata[BANK_LO +: BANK_W];
    assign sel_raddr = mgmt_wdata[RADDR_LO +: ADDR_W];
    assign sel_waddr = mgmt_wdata[WADDR_LO +: ADDR_W];

    mtb_unlock u_unlock (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (mgmt_wdata),
        .open_o    (open_q)
    );

    mtb_bank_store #(
        .BANK_W   (BANK_W),
        .AW       (ADDR_W),
        .DW       (DATA_W),
        .POP_MASK (POP_MASK)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .m_we    (do_wr),
        .m_wbank (sel_bank),
        .m_waddr (sel_waddr),
        .m_wdata (r_q.wr_stage),
        .m_rbank (sel_bank),
        .m_raddr (sel_raddr),
        .m_rdata (str_rdata),
        .i_we    (core_we),
        .i_bank  (core_bank),
        .i_addr  (core_addr),
        .i_wdata (core_wdata),
        .i_rdata (core_rdata)
    );

    always_comb begin
        r_d = r_q;
        if (ctl_we) r_d.ctrl = mgmt_wdata & CTRL_KEEP;
        if (do_rd)  r_d.rd_latch = str_rdata;
        if (mgmt_we && mgmt_addr == WDAT_ADDR) r_d.wr_stage = mgmt_wdata;
        if (mgmt_we && mgmt_addr != CTRL_ADDR && mgmt_addr != RDAT_ADDR
                    && mgmt_addr != WDAT_ADDR)
            r_d.plain[mgmt_addr] = mgmt_wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        case (mgmt_addr)
            CTRL_ADDR: mgmt_rdata = r_q.ctrl;
            RDAT_ADDR: mgmt_rdata = open_q ? r_q.rd_latch : '0;
            WDAT_ADDR: mgmt_rdata = r_q.wr_stage;
            default:   mgmt_rdata = r_q.plain[mgmt_addr];
        endcase
    end

    // R5
    ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we |=> (mgmt_addr != CTRL_ADDR || mgmt_rdata == ($past(mgmt_wdata) & CTRL_KEEP)));

    // R7
    stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mgmt_we && mgmt_addr == WDAT_ADDR) |=> (r_q.wr_stage == $past(mgmt_wdata)));

    // R8
    locked_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_q && mgmt_addr == RDAT_ADDR) |-> (mgmt_rdata == '0));

    // R9
    no_test_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !mgmt_wdata[TEST_BIT] && !(mgmt_we && mgmt_addr == RDAT_ADDR))
        |=> $stable(r_q.rd_latch));
endmodule

// File: tb/mgmt_test_bank_regs_test.sv
module mgmt_test_bank_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mgmt_we = 1'b0;
    logic [4:0]  mgmt_addr = '0;
    logic [15:0] mgmt_wdata = '0;
    logic [15:0] mgmt_rdata;
    logic        core_we = 1'b0;
    logic [1:0]  core_bank = '0;
    logic [4:0]  core_addr = '0;
    logic [15:0] core_wdata = '0;
    logic [15:0] core_rdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mgmt_test_bank_regs uut (
        .clk(clk), .rst_n(rst_n),
        .mgmt_we(mgmt_we), .mgmt_addr(mgmt_addr), .mgmt_wdata(mgmt_wdata),
        .mgmt_rdata(mgmt_rdata),
        .core_we(core_we), .core_bank(core_bank), .core_addr(core_addr),
        .core_wdata(core_wdata), .core_rdata(core_rdata)
    );

    function automatic logic [15:0] pat(int b, int a);
        return 16'((b + 1) * 16'h1357) ^ 16'(a * 16'h0421);
    endfunction

    function automatic logic [15:0] bank_exp(int b, int a);
        return (b == 2) ? 16'h0 : pat(b, a);
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic mwrite(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        mgmt_we = 1'b1; mgmt_addr = a; mgmt_wdata = d;
        @(negedge clk);
        mgmt_we = 1'b0;
    endtask

    task automatic mread(logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        mgmt_we = 1'b0; mgmt_addr = a;
        #1 v = mgmt_rdata;
    endtask

    task automatic cwrite(int b, int a, logic [15:0] d);
        @(negedge clk);
        core_we = 1'b1; core_bank = 2'(b); core_addr = 5'(a); core_wdata = d;
        @(negedge clk);
        core_we = 1'b0;
    endtask

    task automatic cread(int b, int a, output logic [15:0] v);
        @(negedge clk);
        core_bank = 2'(b); core_addr = 5'(a);
        #1 v = core_rdata;
    endtask

    task automatic unlock();
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400);
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400);
    endtask

    function automatic logic [15:0] rd_cmd(int b, int a);
        return 16'h8400 | 16'(b << 11) | 16'(a << 5);
    endfunction

    function automatic logic [15:0] wr_cmd(int b, int a);
        return 16'h4400 | 16'(b << 11) | 16'(a);
    endfunction

    // read probe of bank 0 word 12: nonzero only when open
    task automatic probe(string tag, logic [15:0] exp);
        logic [15:0] v;
        mwrite(5'd20, rd_cmd(0, 12));
        mread(5'd21, v);
        check(tag, v, exp);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] last_latch;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        mread(5'd20, v); check("R1 ctrl", v, 16'h0);
        mread(5'd21, v); check("R1 rdat", v, 16'h0);
        mread(5'd23, v); check("R1 wdat", v, 16'h0);
        mread(5'd22, v); check("R1 plain", v, 16'h0);
        cread(0, 0, v);  check("R1 bank", v, 16'h0);

        // R13 plain registers
        mwrite(5'd22, 16'hA5A5); mwrite(5'd0, 16'h1234);
        mread(5'd22, v); check("R13 plain22", v, 16'hA5A5);
        mread(5'd0, v);  check("R13 plain0", v, 16'h1234);

        // R8 locked commands
        mwrite(5'd23, 16'h7777);
        mread(5'd23, v); check("R7 stage readback", v, 16'h7777);
        mwrite(5'd20, wr_cmd(1, 3));
        cread(1, 3, v); check("R8 locked write", v, 16'h0);
        cwrite(1, 4, 16'h0BAD);
        mwrite(5'd20, rd_cmd(1, 4));
        mread(5'd21, v); check("R8 locked read", v, 16'h0);

        // R2 unlock then sweep every bank word through management
        unlock();
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 32; a++) begin
                mwrite(5'd23, pat(b, a));
                mwrite(5'd20, wr_cmd(b, a));
            end
        end
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 32; a++) begin
                cread(b, a, v);
                check($sformatf("R7 R10 core b%0d a%0d", b, a), v, bank_exp(b, a));
            end
        end
        for (int b = 0; b < 4; b++) begin
            for (int a = 0; a < 32; a++) begin
                mwrite(5'd20, rd_cmd(b, a));
                mread(5'd21, v);
                check($sformatf("R6 R2 mgmt b%0d a%0d", b, a), v, bank_exp(b, a));
            end
        end
        last_latch = bank_exp(3, 31);

        // R5 control readback strips strobes
        mread(5'd20, v); check("R5 ctrl readback", v, rd_cmd(3, 31) & 16'h1FFF);
        mwrite(5'd20, 16'hFFFF);
        mread(5'd20, v); check("R5 ctrl mask", v, 16'h1FFF);

        // R13 address 21 read-only
        mwrite(5'd21, 16'hFFFF);
        mread(5'd21, v); check("R13 rdat readonly", v, last_latch);

        // R9 commands without test-mode bit
        mwrite(5'd23, 16'hDEAD);
        mwrite(5'd20, 16'h4000 | 16'd5);
        cread(0, 5, v); check("R9 write no tm", v, pat(0, 5));
        mwrite(5'd20, 16'h8000 | 16'(1 << 11) | 16'(2 << 5));
        mread(5'd21, v); check("R9 read no tm", v, last_latch);

        // R11 core port writes, R10 bank 2 ignores core writes
        cwrite(3, 7, 16'h0F0F);
        mwrite(5'd20, rd_cmd(3, 7));
        mread(5'd21, v); check("R11 core write seen", v, 16'h0F0F);
        cwrite(2, 7, 16'h1111);
        cread(2, 7, v); check("R10 core bank2", v, 16'h0);

        // R12 same-cycle collision, same word and different words
        mwrite(5'd23, 16'hAAAA);
        @(negedge clk);
        mgmt_we = 1'b1; mgmt_addr = 5'd20; mgmt_wdata = wr_cmd(0, 9);
        core_we = 1'b1; core_bank = 2'd0; core_addr = 5'd9; core_wdata = 16'h5555;
        @(negedge clk);
        mgmt_we = 1'b0; core_we = 1'b0;
        cread(0, 9, v); check("R12 same word", v, 16'hAAAA);
        mwrite(5'd23, 16'hCCCC);
        @(negedge clk);
        mgmt_we = 1'b1; mgmt_addr = 5'd20; mgmt_wdata = wr_cmd(0, 10);
        core_we = 1'b1; core_bank = 2'd0; core_addr = 5'd11; core_wdata = 16'h3333;
        @(negedge clk);
        mgmt_we = 1'b0; core_we = 1'b0;
        cread(0, 10, v); check("R12 mgmt word", v, 16'hCCCC);
        cread(0, 11, v); check("R12 core word", v, 16'h3333);

        // R4 close locks
        probe("R4 open before close", pat(0, 12));
        mwrite(5'd20, 16'h0000);
        probe("R4 closed", 16'h0);
        mwrite(5'd23, 16'h4242);
        mwrite(5'd20, wr_cmd(0, 12));
        cread(0, 12, v); check("R8 write after close", v, pat(0, 12));

        // R2 three steps are not enough
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400); mwrite(5'd20, 16'h0000);
        probe("R2 partial", 16'h0);

        // R3 break by a foreign value
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400); mwrite(5'd20, 16'h0000);
        mwrite(5'd20, 16'h0123); mwrite(5'd20, 16'h0400);
        probe("R3 foreign break", 16'h0);

        // R3 break by 0x0000 restarts the pattern
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400); mwrite(5'd20, 16'h0000);
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400);
        mwrite(5'd20, 16'h0000); mwrite(5'd20, 16'h0400);
        probe("R3 zero restarts", pat(0, 12));

        // R2 other addresses between steps do not interfere
        mwrite(5'd20, 16'h0000);
        mwrite(5'd22, 16'h0400);
        mwrite(5'd20, 16'h0400);
        mwrite(5'd23, 16'h0000);
        mwrite(5'd20, 16'h0000);
        mwrite(5'd1, 16'hFFFF);
        mwrite(5'd20, 16'h0400);
        probe("R2 interleaved", pat(0, 12));

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule